// File: doc/BRIEF.md
# Lockable configuration register bank

This block holds a page of byte-wide configuration registers behind a plain synchronous read/write port, the kind a serial slave decoder drives once it has decoded an address and a data byte. The top address of the page is a command/status register with three control bits. One bit locks the page and tells the upstream link logic to attach. One bit asks the page to reload its defaults for a single cycle. One bit asks the interface to power down. The attach output and the power-down output go to logic outside this block.

Once the page is locked, writes to the protected lower range (00h up to `PROT_TOP`) are dropped. A short parameterized list of port-ownership addresses inside that range stays writable, so ownership can still be changed after attach. The general registers between `PROT_TOP` and the command register also stay writable. The lock and power-down bits are write-once and only the hardware reset clears them. The soft reset is selective: under lock it reloads only the registers that are still writable.

Top module: `lockable_cfg_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register at address a below FFh takes the value a XOR `DEF_MASK`, the command register at FFh takes 00h, `rd_data` takes 00h, and `attach_o` and `pwrdn_o` go low.
- R2: While unlocked, a write with `wr_en` high to any address 00h–FEh stores `wr_data` at the clock edge. A read with `rd_en` high puts that address's value on `rd_data` one clock edge later.
- R3: Bits 7:3 of the command register at FFh always read as zero, and writing ones to them has no effect.
- R4: Writing FFh with bit 0 set raises `attach_o` and sets the lock from the next edge on. Bit 0 reads back as 1. Writing 0 to it later does not clear it; only `rst_n` does.
- R5: While locked, writes to protected addresses (00h through `PROT_TOP`, F0h by default) that are not in the exempt list are dropped, and the stored value stays unchanged.
- R6: While locked, the exempt port-ownership addresses (`EXEMPT_ADDRS`, by default 0Bh, 0Ch, 0Dh, 0Eh, 0Fh) accept writes.
- R7: Addresses above `PROT_TOP` and below FFh (F1h–FEh by default) accept writes whether or not the page is locked.
- R8: Writing FFh with bit 1 set makes bit 1 read as 1 for exactly one cycle. At the next edge the registers are reloaded with their R1 defaults, and bit 1 reads 0 afterwards.
- R9: If the lock is set when a soft reset runs, only exempt addresses and addresses above `PROT_TOP` are reloaded. Other protected registers keep their values, and bits 0 and 2 of FFh keep their values.
- R10: Writing FFh with bit 2 set latches a power-down request, read back as bit 2. This request is write-once and cleared only by `rst_n`. `pwrdn_o` stays low until the first `ack_done` pulse seen after the request is latched, rises at the edge that samples that pulse, and then stays high.
- R11: Reads are served at every address at all times, including while the page is locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe; loads `rd_data` at the edge |
| rd_data | output | DATA_W | Registered read data |
| ack_done | input | 1 | Pulse from the bus engine when an acknowledge has completed |
| attach_o | output | 1 | Attach request and lock indicator |
| pwrdn_o | output | 1 | Interface power-down request |

## Verification
The bench builds the bank with `DEF_MASK` set to C3h, the default exempt list 0Bh–0Fh and `PROT_TOP` at F0h. With these values a reloaded register is easy to tell apart from one written by the bench. They also put both edges of the protected range (F0h dropped, F1h accepted) and a lock-exempt address within a few writes. The bench runs the soft reset both unlocked and locked, so the reload of protected registers can be compared with the reload of open ones. It also sends an acknowledge pulse before and after the power-down request to show which pulse releases `pwrdn_o`.

// File: rtl/cfgbank_pkg.sv
// Package: shared constants and helpers for the lockable configuration bank.
// Assumes byte-or-wider data and a command register at the top address.
package cfgbank_pkg;
    localparam int CMD_LOCK_BIT = 0;
    localparam int CMD_SRST_BIT = 1;
    localparam int CMD_PD_BIT   = 2;
    localparam int CMD_USED     = 3;

    // Default contents of register idx: its address folded with a mask.
    function automatic logic [7:0] def_byte(input int idx, input logic [7:0] mask);
        return 8'(idx) ^ mask;
    endfunction
endpackage

// File: rtl/cfgbank_cmd.sv
// Module: command/status register at the top address.
// Holds the write-once lock and power-down request bits and the
// self-clearing soft-reset pulse, and releases the power-down output on the
// first acknowledge pulse after the request. Assumes wr_cmd is already
// qualified to the command address.
module cfgbank_cmd
    import cfgbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_done,
    output logic              locked,
    output logic              srst,
    output logic              pwrdn,
    output logic [DATA_W-1:0] cmd_word
);
    logic lock_q, srst_q, pd_req_q, pwrdn_q;

    // Write-once lock bit: set by a write of 1, cleared only by rst_n.
    always_ff @(posedge clk) begin
        if (!rst_n)                             lock_q <= 1'b0;
        else if (wr_cmd && wr_data[CMD_LOCK_BIT]) lock_q <= 1'b1;
    end

    // Soft-reset pulse: lasts one cycle, then clears itself.
    always_ff @(posedge clk) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= wr_cmd && wr_data[CMD_SRST_BIT] && !srst_q;
    end

    // Write-once power-down request bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pd_req_q <= 1'b0;
        else if (wr_cmd && wr_data[CMD_PD_BIT]) pd_req_q <= 1'b1;
    end

    // Power-down output: rises on the first acknowledge after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pwrdn_q <= 1'b0;
        else if (pd_req_q && ack_done) pwrdn_q <= 1'b1;
    end

    // Read-back word: reserved bits are always zero.
    always_comb begin
        cmd_word               = '0;
        cmd_word[CMD_LOCK_BIT] = lock_q;
        cmd_word[CMD_SRST_BIT] = srst_q;
        cmd_word[CMD_PD_BIT]   = pd_req_q;
    end

    assign locked = lock_q;
    assign srst   = srst_q;
    assign pwrdn  = pwrdn_q;

    // R4: the lock never drops without rst_n.
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    // R8: the soft-reset pulse lasts a single cycle.
    a_r8_srst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q);
    // R10: power-down rises only after an acknowledge with the request latched.
    a_r10_pd_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwrdn_q) |-> $past(ack_done && pd_req_q));
    // R10: power-down stays asserted.
    a_r10_pd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_q |=> pwrdn_q);
endmodule

// File: rtl/cfgbank_guard.sv
// Module: write-permission decode for the register page.
// Builds, per entry, a write enable and a reload enable that honour the lock,
// the protected range and the exempt list. Assumes the command register sits
// at the top address and is never part of the page's storage.
module cfgbank_guard #(
    parameter int ADDR_W     = 8,
    parameter int PROT_TOP   = 'hF0,
    parameter int NUM_EXEMPT = 5,
    parameter logic [NUM_EXEMPT-1:0][ADDR_W-1:0] EXEMPT_ADDRS = '0
) (
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    locked,
    input  logic                    srst,
    output logic [(1<<ADDR_W)-1:0]  open_map,
    output logic [(1<<ADDR_W)-1:0]  we_vec,
    output logic [(1<<ADDR_W)-1:0]  reload_vec
);
    localparam int NUM_ENT = 1 << ADDR_W;
    localparam int CMD_IDX = NUM_ENT - 1;

    // Elaboration-time check: is this entry writable under the lock?
    function automatic bit entry_open(input int idx);
        if (idx > PROT_TOP) return 1'b1;
        for (int k = 0; k < NUM_EXEMPT; k++)
            if (EXEMPT_ADDRS[k] == ADDR_W'(idx)) return 1'b1;
        return 1'b0;
    endfunction

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        if (i == CMD_IDX) begin : g_cmd
            assign open_map[i]   = 1'b0;
            assign we_vec[i]     = 1'b0;
            assign reload_vec[i] = 1'b0;
        end else begin : g_reg
            localparam bit OPEN = entry_open(i);
            assign open_map[i]   = OPEN;
            // Entry write: addressed and either unlocked or exempt.
            assign we_vec[i]     = wr_en && (addr == ADDR_W'(i)) && (!locked || OPEN);
            // Entry reload: soft reset reaches it unless locked and protected.
            assign reload_vec[i] = srst && (!locked || OPEN);
        end
    end
endmodule

// File: rtl/cfgbank_store.sv
// Module: register storage for the page below the command register.
// Each entry reloads its default on hardware reset or on its reload enable,
// otherwise takes write data on its write enable. The top entry is absent
// and reads as zero. Assumes the enables come from cfgbank_guard.
module cfgbank_store
    import cfgbank_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  DEF_MASK = 8'h5A
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [(1<<ADDR_W)-1:0]               we_vec,
    input  logic [(1<<ADDR_W)-1:0]               reload_vec,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [(1<<ADDR_W)-1:0][DATA_W-1:0]   mem_q
);
    localparam int NUM_ENT = 1 << ADDR_W;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        if (i == NUM_ENT - 1) begin : g_hole
            assign mem_q[i] = '0;
        end else begin : g_reg
            localparam logic [DATA_W-1:0] DEF = DATA_W'(def_byte(i, DEF_MASK));
            // One entry: reload has priority over a write in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n || reload_vec[i]) mem_q[i] <= DEF;
                else if (we_vec[i])          mem_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/lockable_cfg_bank.sv
// Module: top of the lockable configuration register bank.
// Ties the command register, the write guard and the storage together and
// provides the registered read port. Assumes one access per cycle on a
// shared address and a synchronous active-low reset.
module lockable_cfg_bank
    import cfgbank_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 8,
    parameter int          PROT_TOP   = 'hF0,
    parameter int          NUM_EXEMPT = 5,
    parameter logic [NUM_EXEMPT-1:0][ADDR_W-1:0] EXEMPT_ADDRS =
        {8'h0F, 8'h0E, 8'h0D, 8'h0C, 8'h0B},
    parameter logic [7:0]  DEF_MASK   = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ack_done,
    output logic              attach_o,
    output logic              pwrdn_o
);
    localparam int              NUM_ENT  = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_ENT - 1);

    logic                             locked, srst, pwrdn;
    logic [DATA_W-1:0]                cmd_word, rd_word, rd_q;
    logic [NUM_ENT-1:0]               open_map, we_vec, reload_vec;
    logic [NUM_ENT-1:0][DATA_W-1:0]   mem_q;
    logic                             wr_cmd;

    assign wr_cmd = wr_en && (addr == CMD_ADDR);

    cfgbank_cmd #(.DATA_W(DATA_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cmd   (wr_cmd),
        .wr_data  (wr_data),
        .ack_done (ack_done),
        .locked   (locked),
        .srst     (srst),
        .pwrdn    (pwrdn),
        .cmd_word (cmd_word)
    );

    cfgbank_guard #(
        .ADDR_W       (ADDR_W),
        .PROT_TOP     (PROT_TOP),
        .NUM_EXEMPT   (NUM_EXEMPT),
        .EXEMPT_ADDRS (EXEMPT_ADDRS)
    ) u_guard (
        .wr_en      (wr_en),
        .addr       (addr),
        .locked     (locked),
        .srst       (srst),
        .open_map   (open_map),
        .we_vec     (we_vec),
        .reload_vec (reload_vec)
    );

    cfgbank_store #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .DEF_MASK (DEF_MASK)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_vec     (we_vec),
        .reload_vec (reload_vec),
        .wr_data    (wr_data),
        .mem_q      (mem_q)
    );

    // Read mux: command word at the top address, storage elsewhere.
    always_comb rd_word = (addr == CMD_ADDR) ? cmd_word : mem_q[addr];

    // Registered read data, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_word;
    end

    assign rd_data  = rd_q;
    assign attach_o = locked;
    assign pwrdn_o  = pwrdn;

    // R3: reserved command bits never read back as one.
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CMD_ADDR) |=> (rd_data[DATA_W-1:CMD_USED] == '0));

    // R5: a protected entry does not change while the page is locked.
    for (genvar i = 0; i < NUM_ENT - 1; i++) begin : g_chk
        a_r5_protected_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (locked && !open_map[i]) |=> $stable(mem_q[i]));
    end
endmodule

// File: tb/lockable_cfg_bank_bench.sv
module lockable_cfg_bank_bench;
    localparam logic [7:0] MASK = 8'hC3;
    localparam int NVEC = 12;
    // Vector: {is_write, addr, data (write data or expected read)}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 8'hC3},   // R1 default
        {1'b0, 8'h10, 8'hD3},   // R1 default
        {1'b0, 8'hFE, 8'h3D},   // R1 top general register
        {1'b0, 8'hFF, 8'h00},   // R1 command reset value
        {1'b1, 8'h10, 8'h5A},   // R2 write
        {1'b0, 8'h10, 8'h5A},   // R2 read back
        {1'b1, 8'hF5, 8'h77},   // R7 write
        {1'b0, 8'hF5, 8'h77},   // R7 read back
        {1'b1, 8'hFF, 8'hF8},   // R3 reserved ones
        {1'b0, 8'hFF, 8'h00},   // R3 reads zero
        {1'b1, 8'h0B, 8'h11},   // R2 write exempt while unlocked
        {1'b0, 8'h0B, 8'h11}    // R2 read back
    };
    localparam int VREQ [NVEC] = '{1, 1, 1, 1, 2, 2, 7, 7, 3, 3, 2, 2};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       ack_done = 1'b0;
    logic       attach_o, pwrdn_o;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    lockable_cfg_bank #(.DEF_MASK(MASK)) u_lockable_cfg_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .ack_done(ack_done),
        .attach_o(attach_o), .pwrdn_o(pwrdn_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic ack_pulse();
        ack_done = 1'b1;
        @(negedge clk);
        ack_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 attach", {7'b0, attach_o}, 8'h00);
        check("R1 pwrdn", {7'b0, pwrdn_o}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][16]) wr(VEC[i][15:8], VEC[i][7:0]);
            else rd_check($sformatf("R%0d vec %0d", VREQ[i], i), VEC[i][15:8], VEC[i][7:0]);
        end

        // R8 unlocked soft reset reloads everything
        wr(8'hFF, 8'h02);
        @(negedge clk);
        rd_check("R8 unlocked reload 10", 8'h10, 8'h10 ^ MASK);
        rd_check("R8 unlocked reload F5", 8'hF5, 8'hF5 ^ MASK);
        rd_check("R8 bit clear", 8'hFF, 8'h00);
        wr(8'h10, 8'h5A);
        wr(8'hF5, 8'h77);

        // R4 lock
        wr(8'hFF, 8'h01);
        check("R4 attach high", {7'b0, attach_o}, 8'h01);
        rd_check("R4 lock readback", 8'hFF, 8'h01);
        wr(8'hFF, 8'h00);
        check("R4 attach stays", {7'b0, attach_o}, 8'h01);

        // R5 protected writes dropped, R11 reads allowed while locked
        wr(8'h10, 8'h99);
        rd_check("R5 R11 drop 10", 8'h10, 8'h5A);
        wr(8'hF0, 8'h99);
        rd_check("R5 drop F0 edge", 8'hF0, 8'hF0 ^ MASK);
        wr(8'h00, 8'h99);
        rd_check("R5 drop 00", 8'h00, MASK);
        // R6 exempt, R7 open edge
        wr(8'h0B, 8'h22);
        rd_check("R6 exempt 0B", 8'h0B, 8'h22);
        wr(8'h0F, 8'h23);
        rd_check("R6 exempt 0F", 8'h0F, 8'h23);
        wr(8'hF1, 8'h44);
        rd_check("R7 open F1", 8'hF1, 8'h44);

        // R8 visible pulse, R9 selective reload
        wr(8'hFF, 8'h02);
        rd_check("R8 pulse visible", 8'hFF, 8'h03);
        rd_check("R8 self clear", 8'hFF, 8'h01);
        rd_check("R9 protected kept", 8'h10, 8'h5A);
        rd_check("R9 exempt reloaded", 8'h0B, 8'h0B ^ MASK);
        rd_check("R9 open reloaded", 8'hF1, 8'hF1 ^ MASK);
        check("R9 lock kept", {7'b0, attach_o}, 8'h01);

        // R10 power-down
        ack_pulse();
        check("R10 early ack ignored", {7'b0, pwrdn_o}, 8'h00);
        wr(8'hFF, 8'h04);
        check("R10 waits for ack", {7'b0, pwrdn_o}, 8'h00);
        rd_check("R10 request readback", 8'hFF, 8'h05);
        wr(8'hFF, 8'h00);
        rd_check("R10 write once", 8'hFF, 8'h05);
        ack_pulse();
        check("R10 rises after ack", {7'b0, pwrdn_o}, 8'h01);
        @(negedge clk);
        check("R10 stays", {7'b0, pwrdn_o}, 8'h01);

        // R1 hardware reset clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 attach cleared", {7'b0, attach_o}, 8'h00);
        check("R1 pwrdn cleared", {7'b0, pwrdn_o}, 8'h00);
        rd_check("R1 cmd cleared", 8'hFF, 8'h00);
        rd_check("R1 reg reloaded", 8'h10, 8'h10 ^ MASK);

        done = 1'b1;
        finish_run();
    end
endmodule